// File: doc/BRIEF.md
# Motion Event Interrupt Generator

This block watches a stream of three-axis acceleration samples and raises an interrupt when the motion matches a programmed pattern. A `sampleValid` strobe marks each new sample. The block scales the magnitude of each axis down to threshold units and compares it with a 7-bit threshold. Each axis then yields a high event (above the threshold) and a low event (not above it).

A configuration byte selects which of the six events take part and how they combine. There are four rules:

- any enabled event (OR);
- all enabled events together (AND);
- being in a known orientation (position);
- arriving in a known orientation (movement).

A 4D option drops the Z axis from the orientation rules. A duration filter, counted in samples, makes the condition persist before the interrupt is recognised.

The interrupt can follow the condition sample by sample, or it can be latched. When latched, it stays set until the host reads the source byte. The source byte reports the enabled events that were seen, plus an interrupt-active bit.

Top module: `motion_event_irq`

## Requirements
- R1: After reset `irqOut` is 0 and `srcByte` is 8'h00.
- R2: For each axis, the magnitude |sample| is shifted right by SCALE_SHIFT to give the scaled value. A high event is scaled value > `thsReg[6:0]`, and a low event is its complement. `thsReg[7]` is ignored. The source flags are the detected events ANDed with their enables, laid out as `srcByte` bit0 XL, bit1 XH, bit2 YL, bit3 YH, bit4 ZL, bit5 ZH. Bit6 is interrupt-active (equal to `irqOut`) and bit7 is always 0.
- R3: When `cfgReg[7:6]` is 2'b00, the condition is true if any enabled event is present. `cfgReg[5:0]` holds the enables in the same bit order as the flags.
- R4: When `cfgReg[7:6]` is 2'b10, the condition is true only if every enabled event is present. With no enables set, the condition is never true.
- R5: When `cfgReg[7:6]` is 2'b11 (position), the condition is true while the orientation is known. An orientation is known when exactly one considered axis has a high event and that axis's high enable is set.
- R6: When `cfgReg[7:6]` is 2'b01 (movement), the interrupt fires once per arrival in a known orientation. An arrival is a move from unknown into known, or from one known axis to another. The firing sample is the one where the run in the same orientation reaches the duration. Later samples in that orientation do not fire again.
- R7: When `mode4d` is 1 in either orientation mode, the Z axis is not considered, and the Z enables and flags read as 0.
- R8: The duration is D = `durReg[6:0]`, and `durReg[7]` is ignored. The condition must hold on D+1 consecutive samples before the interrupt is recognised. Any failing sample restarts the count.
- R9: When `latchEn` is 0, `irqOut` follows the qualified condition. It drops on the first failing sample, and `srcRead` has no effect.
- R10: When `latchEn` is 1, `irqOut` and the source flags freeze once the interrupt is set. A `srcRead` pulse clears `irqOut` and the whole source byte in the next cycle.
- R11: `irqOut` and `srcByte` change only in the cycle after a `sampleValid` or `srcRead`. They are stable otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | New sample strobe |
| sampleX | input | SAMPLE_W | X axis sample, two's complement |
| sampleY | input | SAMPLE_W | Y axis sample, two's complement |
| sampleZ | input | SAMPLE_W | Z axis sample, two's complement |
| cfgReg | input | 8 | {rule[1:0], ZH, ZL, YH, YL, XH, XL enables} |
| thsReg | input | 8 | Threshold, bits 6:0 used |
| durReg | input | 8 | Duration in samples, bits 6:0 used |
| latchEn | input | 1 | Latch interrupt until source read |
| mode4d | input | 1 | Exclude Z axis in orientation modes |
| srcRead | input | 1 | Source byte read strobe |
| irqOut | output | 1 | Interrupt line |
| srcByte | output | 8 | {0, active, ZH, ZL, YH, YL, XH, XL} |

## Verification
The bench builds the block with SAMPLE_W = 12 and SCALE_SHIFT = 4. One threshold step is therefore 16 raw counts, so the edge between 143 and 144 lands exactly on threshold 8. The full 7-bit threshold range also fits inside the sample range. With these values the bench can hit the threshold boundary from both signs and can use a duration of 2 with the ignored top bit set. It also exercises all four combining rules, including movement between two known orientations and the 4D case.

// File: rtl/mei_pkg.sv
package mei_pkg;

  localparam int AXES = 3;

  typedef enum logic [1:0] {
    MODE_OR   = 2'b00,
    MODE_MOVE = 2'b01,
    MODE_AND  = 2'b10,
    MODE_POS  = 2'b11
  } combMode_t;

  typedef struct packed {
    logic cntStep;    // advance duration run on a new sample
    logic flagLoad;   // capture enabled events into source flags
    logic flagClear;  // wipe source flags after a latched read
  } ctlStrb_t;

endpackage

// File: rtl/mei_datapath.sv
module mei_datapath
  import mei_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int SCALE_SHIFT = 4,
  parameter int THR_W       = 7,
  parameter int DUR_W       = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleX,
  input  logic [SAMPLE_W-1:0] sampleY,
  input  logic [SAMPLE_W-1:0] sampleZ,
  input  logic [7:0]          cfgReg,
  input  logic [7:0]          thsReg,
  input  logic [7:0]          durReg,
  input  logic                mode4d,
  input  ctlStrb_t            strb,
  output logic                qual,
  output logic [2*AXES-1:0]   flagsOut
);

  localparam int CNT_W = DUR_W + 1;
  localparam int EV_W  = 2 * AXES;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SAMPLE_W-1:0] axisSmp [AXES];
  logic [SAMPLE_W-1:0] thsExt;
  logic [AXES-1:0]     hiEv;
  logic [EV_W-1:0]     evVec, effEn, enEv;
  logic [AXES-1:0]     hv, hiEn, zone, prevZone;
  logic                is6d, known, cond, sameKey;
  combMode_t           mode;
  logic [CNT_W-1:0]    runCnt, prior, durVal;
  logic [EV_W-1:0]     flagsQ;

  assign axisSmp[0] = sampleX;
  assign axisSmp[1] = sampleY;
  assign axisSmp[2] = sampleZ;
  assign thsExt     = SAMPLE_W'(thsReg[THR_W-1:0]);

  generate
    for (genvar a = 0; a < AXES; a++) begin : g_axis
      logic [SAMPLE_W-1:0] mag, scaled;
      assign mag         = axisSmp[a][SAMPLE_W-1] ? (~axisSmp[a] + 1'b1) : axisSmp[a];
      assign scaled      = mag >> SCALE_SHIFT;
      assign hiEv[a]     = scaled > thsExt;
      assign evVec[2*a+1] = hiEv[a];
      assign evVec[2*a]   = ~hiEv[a];
      assign hiEn[a]      = effEn[2*a+1];
    end
  endgenerate

  assign mode  = combMode_t'(cfgReg[7:6]);
  assign is6d  = cfgReg[6];
  assign effEn = cfgReg[EV_W-1:0] & ((is6d && mode4d) ? 6'b001111 : 6'b111111);
  assign enEv  = evVec & effEn;

  assign hv    = {hiEv[2] & ~mode4d, hiEv[1], hiEv[0]};
  assign known = $onehot(hv) && |(hv & hiEn);
  assign zone  = known ? hv : '0;

  always_comb begin
    unique case (mode)
      MODE_OR:  cond = |enEv;
      MODE_AND: cond = (effEn != '0) && (enEv == effEn);
      default:  cond = known;
    endcase
  end

  assign sameKey = is6d ? (zone == prevZone) : 1'b1;
  assign prior   = sameKey ? runCnt : '0;
  assign durVal  = CNT_W'(durReg[DUR_W-1:0]);
  assign qual    = cond && ((mode == MODE_MOVE) ? (prior == durVal) : (prior >= durVal));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt   <= '0;
      prevZone <= '0;
    end else if (strb.cntStep) begin
      runCnt   <= cond ? ((prior == CNT_MAX) ? prior : prior + 1'b1) : '0;
      prevZone <= zone;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               flagsQ <= '0;
    else if (strb.flagClear) flagsQ <= '0;
    else if (strb.flagLoad)  flagsQ <= enEv;
  end

  assign flagsOut = flagsQ;

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntStep && !cond) |=> (runCnt == '0));  // R8
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.flagLoad && !strb.flagClear) |=> $stable(flagsQ));  // R11

endmodule

// File: rtl/mei_control.sv
module mei_control
  import mei_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sampleValid,
  input  logic     srcRead,
  input  logic     latchEn,
  input  logic     qual,
  output ctlStrb_t strb,
  output logic     irqQ
);

  logic irqN;

  always_comb begin
    irqN = irqQ;
    if (latchEn && srcRead) irqN = 1'b0;
    if (sampleValid)        irqN = latchEn ? (irqN | qual) : qual;
  end

  always_comb begin
    strb.cntStep   = sampleValid;
    strb.flagLoad  = sampleValid && !(latchEn && irqQ);
    strb.flagClear = latchEn && srcRead && !strb.flagLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= irqN;
  end

  AST_FOLLOW_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (!latchEn && sampleValid && !qual) |=> !irqQ);  // R9
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (latchEn && irqQ && !srcRead) |=> irqQ);  // R10
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (latchEn && srcRead && !(sampleValid && qual)) |=> !irqQ);  // R10
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && !srcRead) |=> $stable(irqQ));  // R11

endmodule

// File: rtl/motion_event_irq.sv
module motion_event_irq
  import mei_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int SCALE_SHIFT = 4,
  parameter int THR_W       = 7,
  parameter int DUR_W       = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleX,
  input  logic [SAMPLE_W-1:0] sampleY,
  input  logic [SAMPLE_W-1:0] sampleZ,
  input  logic [7:0]          cfgReg,
  input  logic [7:0]          thsReg,
  input  logic [7:0]          durReg,
  input  logic                latchEn,
  input  logic                mode4d,
  input  logic                srcRead,
  output logic                irqOut,
  output logic [7:0]          srcByte
);

  ctlStrb_t            strb;
  logic                qual;
  logic                irqQ;
  logic [2*AXES-1:0]   flags;

  mei_datapath #(
    .SAMPLE_W(SAMPLE_W), .SCALE_SHIFT(SCALE_SHIFT), .THR_W(THR_W), .DUR_W(DUR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .sampleX(sampleX), .sampleY(sampleY), .sampleZ(sampleZ),
    .cfgReg(cfgReg), .thsReg(thsReg), .durReg(durReg), .mode4d(mode4d),
    .strb(strb), .qual(qual), .flagsOut(flags)
  );

  mei_control u_ctl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .srcRead(srcRead),
    .latchEn(latchEn), .qual(qual), .strb(strb), .irqQ(irqQ)
  );

  assign irqOut  = irqQ;
  assign srcByte = {1'b0, irqQ, flags};

endmodule

// File: tb/motion_event_irq_bench.sv
module motion_event_irq_bench;

  localparam int SW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] sampleX = '0, sampleY = '0, sampleZ = '0;
  logic [7:0]    cfgReg = '0, thsReg = '0, durReg = '0;
  logic          latchEn = 1'b0, mode4d = 1'b0, srcRead = 1'b0;
  logic          irqOut;
  logic [7:0]    srcByte;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [8:0] expQ [$];
  string      tagQ [$];

  always #4 clk = ~clk;  // 125 MHz

  motion_event_irq #(.SAMPLE_W(SW), .SCALE_SHIFT(4), .THR_W(7), .DUR_W(7)) u_motion_event_irq (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleX(sampleX), .sampleY(sampleY), .sampleZ(sampleZ),
    .cfgReg(cfgReg), .thsReg(thsReg), .durReg(durReg),
    .latchEn(latchEn), .mode4d(mode4d), .srcRead(srcRead),
    .irqOut(irqOut), .srcByte(srcByte)
  );

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s irq/src actual=%0h_%02h expected=%0h_%02h", tag, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  // Driver: one sample per call, expected result queued for the monitor
  task automatic smp(input int x, input int y, input int z, input logic [7:0] expSrc, input string tag);
    @(negedge clk);
    sampleX = SW'(x); sampleY = SW'(y); sampleZ = SW'(z);
    sampleValid = 1'b1;
    expQ.push_back({expSrc[6], expSrc});
    tagQ.push_back(tag);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] expSrc, input string tag);
    @(negedge clk);
    srcRead = 1'b1;
    expQ.push_back({expSrc[6], expSrc});
    tagQ.push_back(tag);
    @(negedge clk);
    srcRead = 1'b0;
  endtask

  // Monitor: after each strobed edge, compare on the next falling edge
  initial begin
    forever begin
      logic cap;
      @(posedge clk);
      cap = sampleValid || srcRead;
      @(negedge clk);
      if (cap && rstN) begin
        if (expQ.size() == 0) begin
          check("monitor underflow", 9'h1ff, 9'h000);
        end else begin
          logic [8:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, {irqOut, srcByte}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset state", {irqOut, srcByte}, 9'h000);

    // R2/R3 threshold edge, OR mode, XH only
    thsReg = 8'h08; cfgReg = 8'h02;
    smp(143, 0, 0, 8'h00, "R2 below edge");
    smp(144, 0, 0, 8'h42, "R2 R3 at edge");
    smp(-144, 0, 0, 8'h42, "R2 negative edge");
    thsReg = 8'h88;
    smp(144, 0, 0, 8'h42, "R2 ths bit7 ignored");
    smp(143, 0, 0, 8'h00, "R9 drop on first fail");

    // R3 all lows
    thsReg = 8'h08; cfgReg = 8'h3F;
    smp(0, 0, 0, 8'h55, "R3 OR of low events");

    // R4 AND mode
    cfgReg = 8'hAA;
    smp(400, 400, 0, 8'h0A, "R4 partial AND");
    smp(400, 400, 400, 8'h6A, "R4 full AND");
    cfgReg = 8'h80;
    smp(400, 0, 0, 8'h00, "R4 no enables");

    // R5 position
    cfgReg = 8'hEA;
    smp(400, 0, 0, 8'h42, "R5 known zone");
    smp(400, 400, 0, 8'h0A, "R5 ambiguous zone");

    // R7 4D
    mode4d = 1'b1;
    smp(0, 0, 400, 8'h00, "R7 Z ignored");
    smp(400, 0, 400, 8'h42, "R7 X known with Z high");
    mode4d = 1'b0;

    // R6 movement
    cfgReg = 8'h6A;
    smp(0, 0, 0, 8'h00, "R6 unknown");
    smp(400, 0, 0, 8'h42, "R6 enter known");
    smp(400, 0, 0, 8'h02, "R6 no refire");
    smp(0, 400, 0, 8'h48, "R6 zone change");

    // R8 duration 2 (bit7 ignored)
    cfgReg = 8'h02; durReg = 8'h82;
    smp(0, 0, 0, 8'h00, "R8 clear run");
    smp(400, 0, 0, 8'h02, "R8 run 1");
    smp(400, 0, 0, 8'h02, "R8 run 2");
    smp(400, 0, 0, 8'h42, "R8 run 3 fires");
    smp(400, 0, 0, 8'h42, "R8 held");
    smp(0, 0, 0, 8'h00, "R9 fail resets");
    smp(400, 0, 0, 8'h02, "R8 count restarted");

    // R10 latch
    durReg = 8'h00; latchEn = 1'b1;
    smp(0, 0, 0, 8'h00, "R10 idle");
    smp(400, 0, 0, 8'h42, "R10 set");
    smp(0, 0, 0, 8'h42, "R10 held frozen");
    rd(8'h00, "R10 read clears");
    smp(0, 0, 0, 8'h00, "R10 after read");

    // R9/R11 read ignored when not latched
    latchEn = 1'b0;
    smp(400, 0, 0, 8'h42, "R9 set unlatched");
    rd(8'h42, "R9 R11 read no effect");

    repeat (4) @(negedge clk);
    check("R11 queue drained", 9'(expQ.size()), 9'h000);
    check("R11 idle stable", {irqOut, srcByte}, 9'h142);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule